// File: doc/BRIEF.md
# Sixteen-bit compare timer with forced-match strobes

This block is a 16-bit up-counter with three compare channels (A, B and C). Each channel drives one output pin. A 4-bit address, 8-bit data register bus reaches the counter, the compare values, a control byte, a force byte and a flag byte.

Counting advances on a one-cycle `tick` enable. When the counter equals a channel's compare value on a tick, that channel's flag is set and its pin takes the action selected for it. In clear-on-match mode, a match on channel A returns the counter to zero in place of the increment. Software can also strobe a forced match per channel. A forced match applies the pin action only, unless the `pwmMode` input marks a PWM waveform mode as active, in which case it does nothing.

The 16-bit values are moved through one shared 8-bit holding byte, so each transfer is atomic. Reading a low byte captures the matching high byte into the holding byte. Writing a high byte only fills the holding byte, and the following low-byte write commits all sixteen bits together.

Top module: `tcu_top`

## Requirements
- R1: After reset, the counter, all compare values, the control byte, the holding byte, all pins and all flags are zero.
- R2: A write to a high-byte address (3 counter, 5/7/9 compare A/B/C) only loads the holding byte and leaves the register unchanged. A write to the low-byte address (2 counter, 4/6/8 compare A/B/C) loads the register with {holding byte, written byte} in one step.
- R3: A read of a low-byte address returns that register's low byte in the same cycle and copies its high byte into the holding byte. A read of any high-byte address returns the holding byte, even if the counter has moved on since.
- R4: In normal mode (control bit 6 = 0), each tick adds one to the counter, wrapping 0xFFFF to 0x0000. That wrap sets the overflow flag, which is flag byte bit 3 at address 10. Without a tick or a write, the counter holds.
- R5: In clear-on-match mode (control bit 6 = 1), a tick on which the counter equals compare A loads zero into the counter instead of the increment, and sets flag A.
- R6: A tick on which the counter equals a channel's compare value sets that channel's flag (bit 0 A, bit 1 B, bit 2 C), effective at that clock edge. It also applies the channel's pin action from its 2-bit control field: A at bits 1:0, B at 3:2, C at 5:4. The encoding is 00 no change, 01 toggle, 10 drive low, 11 drive high.
- R7: Writing a one to force bit 7 (A), 6 (B) or 5 (C) at address 1 applies that channel's current pin action at the end of the write cycle. It sets no flag and never clears the counter, even in clear-on-match mode.
- R8: While `pwmMode` is high, force writes have no effect on the pins.
- R9: Address 1 always reads zero, including its unused bits 4:0. Control bit 7 reads zero.
- R10: A write of the counter's low byte suppresses compare matches on all channels for the next tick.
- R11: Writing a one to a flag bit clears it. If a new event for that flag happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer count enable, one cycle per count |
| pwmMode | input | 1 | High when a PWM waveform mode is active; blocks forced matches |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe; captures the holding byte on low-byte reads |
| busRdData | output | 8 | Read data for busAddr, combinational |
| ocPin | output | 3 | Compare output pins, bit 0 = A |
| irqFlag | output | 4 | Flags: bits 2:0 channel matches, bit 3 overflow |

## Verification
Read data depends on the address within the same cycle, so the bench samples it two nanoseconds after driving the address and before the clock edge. Pins, flags, the counter and the holding byte all update at the clock edge that ends the tick or write cycle. The bench therefore compares them at the next falling edge, exactly one cycle after the stimulus. The counter mask is the only effect that reaches further. Its effect is checked on the first tick after the counter write and then on the tick after that, where a match is counted again. A bench model steps on the same edges, which keeps the random phase aligned cycle by cycle.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int CNT_W    = 16;
  localparam int BUS_W    = 8;
  localparam int NUM_CH   = 3;
  localparam int ADDR_W   = 4;
  localparam int FLAG_W   = NUM_CH + 1;
  localparam int CTRL_W   = 2 * NUM_CH + 1;
  localparam int MODE_BIT = 2 * NUM_CH;

  localparam int ADR_CMP_BASE = 4;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_FORCE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_CNT_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_CNT_HI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_FLAGS  = ADDR_W'(ADR_CMP_BASE + 2 * NUM_CH);

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pinAct_e;

  typedef struct packed {
    logic              cntLoad;
    logic [NUM_CH-1:0] cmpLoad;
    logic [CNT_W-1:0]  loadVal;
    logic [NUM_CH-1:0] forceCh;
    logic [FLAG_W-1:0] flagClr;
  } tcuStrobe_t;
endpackage

// File: rtl/tcu_channel.sv
module tcu_channel
  import tcu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             maskActive,
  input  logic             cmpLoad,
  input  logic             forceCh,
  input  logic             flagClr,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [1:0]       actSel,
  output logic [CNT_W-1:0] cmpVal,
  output logic             matchEv,
  output logic             ocPin,
  output logic             flagOut
);
  logic [CNT_W-1:0] cmpReg;
  logic             pinReg;
  logic             flagReg;
  logic             pinNext;
  logic             actNow;

  assign matchEv = tick && !maskActive && (cntVal == cmpReg);
  assign actNow  = matchEv || forceCh;

  always_comb begin
    case (pinAct_e'(actSel))
      ACT_TOGGLE: pinNext = ~pinReg;
      ACT_LOW:    pinNext = 1'b0;
      ACT_HIGH:   pinNext = 1'b1;
      default:    pinNext = pinReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg  <= '0;
      pinReg  <= 1'b0;
      flagReg <= 1'b0;
    end else begin
      if (cmpLoad) cmpReg <= loadVal;
      if (actNow)  pinReg <= pinNext;
      flagReg <= (flagReg && !flagClr) || matchEv;
    end
  end

  assign cmpVal  = cmpReg;
  assign ocPin   = pinReg;
  assign flagOut = flagReg;

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!forceCh && !matchEv) |=> $stable(ocPin)) else $error("pin moved without event"); // R6
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (forceCh && !matchEv && !flagOut) |=> !flagOut) else $error("force set a flag"); // R7
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !matchEv) |=> !flagOut) else $error("flag not cleared"); // R11
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    matchEv |=> flagOut) else $error("match lost against clear"); // R11
endmodule

// File: rtl/tcu_datapath.sv
module tcu_datapath
  import tcu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  tcuStrobe_t                    strb,
  input  logic                          clrOnMatchA,
  input  logic [NUM_CH-1:0][1:0]        actSel,
  output logic [CNT_W-1:0]              cntVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmpVal,
  output logic [NUM_CH-1:0]             ocPin,
  output logic [FLAG_W-1:0]             flagVal
);
  logic [CNT_W-1:0]  cntReg;
  logic              maskActive;
  logic              ovfReg;
  logic              ovfEv;
  logic              clearEv;
  logic [NUM_CH-1:0] matchEv;
  logic [NUM_CH-1:0] chFlag;

  assign ovfEv   = tick && !clrOnMatchA && (cntReg == {CNT_W{1'b1}});
  assign clearEv = clrOnMatchA && matchEv[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg     <= '0;
      maskActive <= 1'b0;
      ovfReg     <= 1'b0;
    end else begin
      if (strb.cntLoad)  cntReg <= strb.loadVal;
      else if (tick)     cntReg <= clearEv ? '0 : cntReg + 1'b1;
      if (strb.cntLoad)  maskActive <= 1'b1;
      else if (tick)     maskActive <= 1'b0;
      ovfReg <= (ovfReg && !strb.flagClr[NUM_CH]) || ovfEv;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    tcu_channel uChan (
      .clk        (clk),
      .rstN       (rstN),
      .tick       (tick),
      .maskActive (maskActive),
      .cmpLoad    (strb.cmpLoad[g]),
      .forceCh    (strb.forceCh[g]),
      .flagClr    (strb.flagClr[g]),
      .cntVal     (cntReg),
      .loadVal    (strb.loadVal),
      .actSel     (actSel[g]),
      .cmpVal     (cmpVal[g]),
      .matchEv    (matchEv[g]),
      .ocPin      (ocPin[g]),
      .flagOut    (chFlag[g])
    );
  end

  assign cntVal  = cntReg;
  assign flagVal = {ovfReg, chFlag};

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.cntLoad && !clearEv) |=> cntReg == CNT_W'($past(cntReg) + 1'b1))
    else $error("counter did not step"); // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strb.cntLoad) |=> $stable(cntReg)) else $error("counter moved"); // R4
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !clrOnMatchA && !strb.cntLoad && cntReg == {CNT_W{1'b1}}) |=> (ovfReg && cntReg == '0))
    else $error("wrap missed"); // R4
  AST_MATCH_A_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (tick && clrOnMatchA && matchEv[0] && !strb.cntLoad) |=> cntReg == '0)
    else $error("clear-on-match failed"); // R5
  AST_WRITE_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> matchEv == '0) else $error("match after counter write"); // R10
endmodule

// File: rtl/tcu_ctrl.sv
module tcu_ctrl
  import tcu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pwmMode,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWrEn,
  input  logic [BUS_W-1:0]              busWrData,
  input  logic                          busRdEn,
  output logic [BUS_W-1:0]              busRdData,
  input  logic [CNT_W-1:0]              cntVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cmpVal,
  input  logic [FLAG_W-1:0]             flagVal,
  output tcuStrobe_t                    strb,
  output logic                          clrOnMatchA,
  output logic [NUM_CH-1:0][1:0]        actSel
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [BUS_W-1:0]  tempReg;
  logic [BUS_W-1:0]  cmpHiSel;
  logic [NUM_CH-1:0] selCmpLo;
  logic [NUM_CH-1:0] selCmpHi;
  logic selCtrl, selForce, selCntLo, selCntHi, selFlags, selAnyHi;

  always_comb begin
    cmpHiSel = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      selCmpLo[ch] = (busAddr == ADDR_W'(ADR_CMP_BASE + 2 * ch));
      selCmpHi[ch] = (busAddr == ADDR_W'(ADR_CMP_BASE + 2 * ch + 1));
      if (selCmpLo[ch]) cmpHiSel = cmpVal[ch][CNT_W-1:BUS_W];
    end
  end

  assign selCtrl  = (busAddr == ADR_CTRL);
  assign selForce = (busAddr == ADR_FORCE);
  assign selCntLo = (busAddr == ADR_CNT_LO);
  assign selCntHi = (busAddr == ADR_CNT_HI);
  assign selFlags = (busAddr == ADR_FLAGS);
  assign selAnyHi = selCntHi || (|selCmpHi);

  always_comb begin
    strb         = '0;
    strb.cntLoad = busWrEn && selCntLo;
    strb.cmpLoad = {NUM_CH{busWrEn}} & selCmpLo;
    strb.loadVal = {tempReg, busWrData};
    for (int ch = 0; ch < NUM_CH; ch++)
      strb.forceCh[ch] = busWrEn && selForce && busWrData[BUS_W-1-ch] && !pwmMode;
    strb.flagClr = (busWrEn && selFlags) ? busWrData[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      tempReg <= '0;
    end else begin
      if (busWrEn && selCtrl) ctrlReg <= busWrData[CTRL_W-1:0];
      if (busWrEn && selAnyHi)              tempReg <= busWrData;
      else if (busRdEn && selCntLo)         tempReg <= cntVal[CNT_W-1:BUS_W];
      else if (busRdEn && (|selCmpLo))      tempReg <= cmpHiSel;
    end
  end

  always_comb begin
    busRdData = '0;
    if (selCtrl)  busRdData = BUS_W'(ctrlReg);
    if (selCntLo) busRdData = cntVal[BUS_W-1:0];
    if (selAnyHi) busRdData = tempReg;
    if (selFlags) busRdData = BUS_W'(flagVal);
    for (int ch = 0; ch < NUM_CH; ch++)
      if (selCmpLo[ch]) busRdData = cmpVal[ch][BUS_W-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gAct
    assign actSel[g] = ctrlReg[2*g +: 2];
  end
  assign clrOnMatchA = ctrlReg[MODE_BIT];

  AST_HI_WRITE_ONLY_TEMP: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && selCmpHi[0]) |=> $stable(cmpVal[0])) else $error("high write changed register"); // R2
  AST_LO_WRITE_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && selCmpLo[0]) |=> cmpVal[0] == $past({tempReg, busWrData}))
    else $error("low write did not commit"); // R2
  AST_READ_LATCHES_HI: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && selCntLo) |=> tempReg == $past(cntVal[CNT_W-1:BUS_W]))
    else $error("high byte not captured"); // R3
endmodule

// File: rtl/tcu_top.sv
module tcu_top
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              pwmMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busRdEn,
  output logic [BUS_W-1:0]  busRdData,
  output logic [NUM_CH-1:0] ocPin,
  output logic [FLAG_W-1:0] irqFlag
);
  tcuStrobe_t                   strb;
  logic                         clrOnMatchA;
  logic [NUM_CH-1:0][1:0]       actSel;
  logic [CNT_W-1:0]             cntVal;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpVal;

  tcu_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .pwmMode     (pwmMode),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .busRdEn     (busRdEn),
    .busRdData   (busRdData),
    .cntVal      (cntVal),
    .cmpVal      (cmpVal),
    .flagVal     (irqFlag),
    .strb        (strb),
    .clrOnMatchA (clrOnMatchA),
    .actSel      (actSel)
  );

  tcu_datapath uDp (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .strb        (strb),
    .clrOnMatchA (clrOnMatchA),
    .actSel      (actSel),
    .cntVal      (cntVal),
    .cmpVal      (cmpVal),
    .ocPin       (ocPin),
    .flagVal     (irqFlag)
  );

  AST_PWM_BLOCKS_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && !tick && busWrEn && busAddr == ADR_FORCE) |=> $stable(ocPin))
    else $error("force acted in pwm mode"); // R8
  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADR_FORCE) |-> busRdData == '0) else $error("force byte read nonzero"); // R9
endmodule

// File: tb/test_tcu_top.sv
module test_tcu_top;
  import tcu_pkg::*;

  logic       clk = 1'b0;
  logic       rstN, tick, pwmMode, busWrEn, busRdEn;
  logic [3:0] busAddr;
  logic [7:0] busWrData, busRdData;
  logic [2:0] ocPin;
  logic [3:0] irqFlag;

  int checks = 0;
  int failures = 0;
  logic [7:0] lastRd;

  logic [15:0] mCnt;
  logic [15:0] mCmp [3];
  logic [1:0]  mAct [3];
  logic [2:0]  mPin;
  logic [3:0]  mFlag;
  logic        mClr, mMask;
  logic [7:0]  mTemp;

  always #10 clk = ~clk;

  tcu_top i_tcu_top (
    .clk(clk), .rstN(rstN), .tick(tick), .pwmMode(pwmMode),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .ocPin(ocPin), .irqFlag(irqFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic w, input logic [3:0] a, input logic [7:0] d,
                           input logic r, input logic t);
    logic [2:0] ev;
    logic [2:0] frc;
    logic       ovf;
    logic [7:0] nTemp;
    nTemp = mTemp;
    if (w && (a == 3 || a == 5 || a == 7 || a == 9)) nTemp = d;
    else if (r && a == 2) nTemp = mCnt[15:8];
    else if (r && (a == 4 || a == 6 || a == 8)) nTemp = mCmp[(a - 4) / 2][15:8];
    for (int i = 0; i < 3; i++) begin
      ev[i]  = t && !mMask && (mCnt == mCmp[i]);
      frc[i] = w && a == 1 && d[7-i] && !pwmMode;
    end
    ovf = t && !mClr && mCnt == 16'hFFFF;
    for (int i = 0; i < 3; i++)
      if (ev[i] || frc[i])
        case (mAct[i])
          2'b01: mPin[i] = ~mPin[i];
          2'b10: mPin[i] = 1'b0;
          2'b11: mPin[i] = 1'b1;
          default: ;
        endcase
    mFlag = (mFlag & ((w && a == 10) ? ~d[3:0] : 4'hF)) | {ovf, ev};
    if (w && a == 2) mCnt = {mTemp, d};
    else if (t) mCnt = (mClr && ev[0]) ? 16'h0 : mCnt + 16'h1;
    if (w && a == 2) mMask = 1'b1;
    else if (t) mMask = 1'b0;
    for (int i = 0; i < 3; i++)
      if (w && a == 4'(4 + 2 * i)) mCmp[i] = {mTemp, d};
    if (w && a == 0) begin
      for (int i = 0; i < 3; i++) mAct[i] = d[2*i +: 2];
      mClr = d[6];
    end
    mTemp = nTemp;
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d,
                     input logic r, input logic t);
    busWrEn = w; busAddr = a; busWrData = d; busRdEn = r; tick = t;
    #2;
    lastRd = busRdData;
    modelStep(w, a, d, r, t);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic wr16(input logic [3:0] aLo, input logic [15:0] v);
    wr8(aLo + 4'd1, v[15:8]);
    wr8(aLo, v[7:0]);
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    cyc(1'b0, a, 8'h00, 1'b1, 1'b0);
    check(tag, 32'(lastRd), 32'(exp));
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 4'd0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic checkState(input string tag);
    check({tag, " pins"}, 32'(ocPin), 32'(mPin));
    check({tag, " flags"}, 32'(irqFlag), 32'(mFlag));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; tick = 1'b0; pwmMode = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0;
    busAddr = 4'd0; busWrData = 8'h00;
    mCnt = 0; mPin = 0; mFlag = 0; mClr = 0; mMask = 0; mTemp = 0;
    for (int i = 0; i < 3; i++) begin mCmp[i] = 0; mAct[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 pins", 32'(ocPin), 32'h0);
    check("R1 flags", 32'(irqFlag), 32'h0);
    rdChk(ADR_CNT_LO, 8'h00, "R1 count");
    rdChk(ADR_CTRL, 8'h00, "R1 ctrl");
    rdChk(4'd8, 8'h00, "R1 compare C");

    // R2 atomic write
    wr8(4'd5, 8'h12);
    rdChk(4'd4, 8'h00, "R2 high write alone, low byte");
    rdChk(4'd5, 8'h00, "R2 high write alone, high byte");
    wr16(4'd4, 16'h1234);
    rdChk(4'd4, 8'h34, "R2 commit low");
    rdChk(4'd5, 8'h12, "R2 commit high");

    // R3 read latch
    wr16(ADR_CNT_LO, 16'h00FE);
    rdChk(ADR_CNT_LO, 8'hFE, "R3 low read");
    ticks(3);
    rdChk(ADR_CNT_HI, 8'h00, "R3 latched high");
    rdChk(ADR_CNT_LO, 8'h01, "R3 moved low");
    rdChk(ADR_CNT_HI, 8'h01, "R3 moved high");

    // R4 wrap and overflow flag
    wr16(ADR_CNT_LO, 16'hFFFE);
    ticks(2);
    check("R4 overflow flag", 32'(irqFlag), 32'h8);
    rdChk(ADR_CNT_LO, 8'h00, "R4 wrap low");
    rdChk(ADR_CNT_HI, 8'h00, "R4 wrap high");

    // R11 clear, then set wins over clear
    wr8(ADR_FLAGS, 8'h08);
    check("R11 cleared", 32'(irqFlag), 32'h0);
    wr16(ADR_CNT_LO, 16'hFFFF);
    cyc(1'b1, ADR_FLAGS, 8'h08, 1'b0, 1'b1);
    check("R11 set wins", 32'(irqFlag), 32'h8);
    wr8(ADR_FLAGS, 8'h0F);

    // R6 real matches with toggle/high/low actions
    wr8(ADR_CTRL, 8'h2D);
    wr16(4'd4, 16'h0010); wr16(4'd6, 16'h0010); wr16(4'd8, 16'h0010);
    wr16(ADR_CNT_LO, 16'h000E);
    ticks(3);
    check("R6 pins", 32'(ocPin), 32'h3);
    check("R6 flags", 32'(irqFlag), 32'h7);
    wr8(ADR_FLAGS, 8'h07);

    // R5 clear-on-match
    wr8(ADR_CTRL, 8'h41);
    wr16(4'd4, 16'h0005);
    wr16(ADR_CNT_LO, 16'h0003);
    ticks(3);
    check("R5 flag A", 32'(irqFlag), 32'h1);
    check("R5 pin A toggled", 32'(ocPin), 32'h2);
    rdChk(ADR_CNT_LO, 8'h00, "R5 counter cleared low");
    rdChk(ADR_CNT_HI, 8'h00, "R5 counter cleared high");
    wr8(ADR_FLAGS, 8'h0F);

    // R10 mask after counter write
    wr8(ADR_CTRL, 8'h04);
    wr16(4'd6, 16'h0020);
    wr16(ADR_CNT_LO, 16'h0020);
    ticks(1);
    check("R10 masked flag", 32'(irqFlag), 32'h0);
    check("R10 masked pin", 32'(ocPin), 32'h2);
    wr16(ADR_CNT_LO, 16'h001F);
    ticks(2);
    check("R10 unmasked flag", 32'(irqFlag), 32'h2);
    check("R10 unmasked pin", 32'(ocPin), 32'h0);
    wr8(ADR_FLAGS, 8'h0F);

    // R7 forced match
    wr8(ADR_CTRL, 8'h79);
    wr16(4'd4, 16'h0040);
    wr16(ADR_CNT_LO, 16'h0040);
    wr8(ADR_FORCE, 8'hE0);
    check("R7 forced pins", 32'(ocPin), 32'h5);
    check("R7 no flag", 32'(irqFlag), 32'h0);
    rdChk(ADR_CNT_LO, 8'h40, "R7 counter kept");

    // R8 force blocked in PWM mode, R9 readback zero
    pwmMode = 1'b1;
    wr8(ADR_FORCE, 8'hE0);
    check("R8 pins unchanged", 32'(ocPin), 32'h5);
    wr8(ADR_FORCE, 8'hFF);
    check("R8 pins unchanged again", 32'(ocPin), 32'h5);
    rdChk(ADR_FORCE, 8'h00, "R9 force reads zero");
    pwmMode = 1'b0;
    wr8(ADR_CTRL, 8'hFF);
    rdChk(ADR_CTRL, 8'h7F, "R9 ctrl bit 7 zero");
    checkState("R7 model");

    // random phase against the bench model (R6, R4)
    void'($urandom(32'd20240611));
    for (int rnd = 0; rnd < 30; rnd++) begin
      logic [15:0] base;
      base = 16'($urandom);
      if (rnd % 5 == 0) base = 16'hFFF8;
      wr8(ADR_CTRL, 8'($urandom) & 8'h7F);
      for (int i = 0; i < 3; i++) wr16(4'(4 + 2 * i), base + 16'($urandom_range(6, 0)));
      wr16(ADR_CNT_LO, base - 16'($urandom_range(3, 0)));
      for (int c = 0; c < 14; c++) begin
        int pick;
        logic tk;
        pick = $urandom_range(9, 0);
        tk = ($urandom_range(3, 0) != 0);
        if (pick == 0) cyc(1'b1, ADR_FORCE, 8'($urandom) & 8'hE0, 1'b0, tk);
        else if (pick == 1) cyc(1'b1, ADR_FLAGS, 8'($urandom) & 8'h0F, 1'b0, tk);
        else cyc(1'b0, 4'd0, 8'h00, 1'b0, tk);
        checkState("R6 random");
      end
      rdChk(ADR_CNT_LO, mCnt[7:0], "R4 random count low");
      rdChk(ADR_CNT_HI, mTemp, "R3 random count high");
      wr8(ADR_FLAGS, 8'h0F);
    end

    busWrEn = 1'b0; busRdEn = 1'b0; tick = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule